// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Wakeup Standby

This block receives 8-bit or 9-bit asynchronous characters from a single serial line. It samples the line with a 16x oversampling tick from an external baud generator. A three-sample majority vote at the middle of each bit gives the bit value. Each accepted character appears on a data bus, together with a one-cycle data-ready pulse. A level flag reports when the line has been idle for a full character time.

Software can put the receiver into a standby state with a one-cycle write strobe. While in standby, characters are still assembled but are not reported. Hardware clears standby by itself when the selected wakeup event occurs. With the wakeup select at 0, that event is an idle line. With the wakeup select at 1, it is a character whose most significant data bit is 1. In a multi-drop link, this lets a node skip traffic meant for others until an idle gap or an address character arrives.

Top module: `uart_rx_wake`

## Requirements
- R1: While `rx_en_i` is 0 the receiver ignores the line completely: no data-ready pulse, `idle_o` stays 0, and a character in progress is abandoned.
- R2: A frame is one start bit (0), then the data bits least significant first, then one stop bit (1). In 8-bit mode (`char9_i` = 0) the character appears on `rx_data_o[7:0]` with `rx_data_o[8]` = 0. `rx_valid_o` pulses for exactly one clock cycle per accepted character.
- R3: With `char9_i` = 1 a frame carries 9 data bits, and the ninth received bit appears on `rx_data_o[8]`. The most significant data bit is bit 8 in 9-bit mode and bit 7 in 8-bit mode.
- R4: Each bit is decided by majority over the samples at oversample ticks 7, 8 and 9 of the bit. A falling edge whose start-bit majority is 1 is dropped as a glitch, and the receiver then waits for a new start.
- R5: A character whose stop-bit majority is 0 is discarded and produces no data-ready pulse.
- R6: `idle_o` rises after the line has been high, with no character in progress, for (data bits + 2) x 16 oversample ticks. It falls when the line goes low.
- R7: A strobe on `standby_wr_i` loads `standby_wdata_i` into `standby_o`. Writing 1 enters standby and writing 0 leaves it. A write takes priority over a hardware wakeup in the same cycle.
- R8: In standby with `wake_sel_i` = 0, received characters give no data-ready pulse. Standby clears on its own when `idle_o` rises, and the next character is then delivered.
- R9: In standby with `wake_sel_i` = 1, characters whose most significant data bit is 0 are dropped and idle periods have no effect. A character whose most significant data bit is 1 clears standby and is itself delivered with a data-ready pulse.
- R10: After reset `rx_valid_o`, `rx_data_o`, `idle_o` and `standby_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line_i | input | 1 | Serial line, idle high |
| os_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en_i | input | 1 | Receiver enable |
| wake_sel_i | input | 1 | Wakeup event: 0 idle line, 1 address mark |
| standby_wr_i | input | 1 | Write strobe for the standby bit |
| standby_wdata_i | input | 1 | Value written to the standby bit |
| char9_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rx_data_o | output | 9 | Last delivered character |
| rx_valid_o | output | 1 | Data-ready pulse, one cycle per character |
| idle_o | output | 1 | Line idle for a full character time |
| standby_o | output | 1 | Receiver is in standby |

## Verification
The hardest case to reach is the idle-line wakeup. Standby must be entered while the line is already idle, and then a character must arrive and be swallowed. Only the idle period that follows that character may clear standby. The bench sets standby after a long quiet period. It checks that the bit stays set, sends a character and checks that it is not delivered, then waits twelve bit times and checks that standby has cleared and that the next character is reported. For address-mark mode, an idle gap is placed between the mark-less and the marked character, which shows that idle periods are ignored in that mode.

// File: rtl/uart_rx_wake_pkg.sv
package uart_rx_wake_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
  import uart_rx_wake_pkg::*;
#(
  parameter int unsigned OS = 16,
  parameter int unsigned DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          line_i,
  input  logic          char9_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          busy_o
);
  localparam int unsigned CW  = $clog2(OS);
  localparam int unsigned IW  = $clog2(DW + 1);
  localparam int unsigned MID = OS / 2 - 1;

  rx_state_e       st;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   idx;
  logic [2:0]      smp;
  logic [IW-1:0]   nbits;
  logic            maj;
  logic            last_tick;

  assign nbits     = char9_i ? IW'(DW) : IW'(DW - 1);
  assign maj       = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
  assign last_tick = (cnt == CW'(OS - 1));
  assign busy_o    = (st != RX_IDLE);

  always_ff @(posedge clk) begin
    done_o <= 1'b0;
    if (rst || !en_i) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      idx    <= '0;
      smp    <= '0;
      data_o <= '0;
    end else if (tick_i) begin
      if (st == RX_IDLE) begin
        if (!line_i) begin
          st  <= RX_START;
          cnt <= '0;
        end
      end else begin
        cnt <= last_tick ? '0 : cnt + 1'b1;
        if (cnt == CW'(MID))     smp[0] <= line_i;
        if (cnt == CW'(MID + 1)) smp[1] <= line_i;
        if (cnt == CW'(MID + 2)) smp[2] <= line_i;
        if (last_tick) begin
          case (st)
            RX_START: begin
              if (maj) st <= RX_IDLE;
              else begin
                st     <= RX_DATA;
                idx    <= '0;
                data_o <= '0;
              end
            end
            RX_DATA: begin
              data_o[idx] <= maj;
              idx         <= idx + 1'b1;
              if (idx == nbits - 1'b1) st <= RX_STOP;
            end
            default: begin
              st     <= RX_IDLE;
              done_o <= maj;
            end
          endcase
        end
      end
    end
  end

  p_index_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (st == RX_DATA) |-> (idx < nbits));

  p_abort_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!busy_o && !done_o));
endmodule

// File: rtl/rx_idle_det.sv
module rx_idle_det #(
  parameter int unsigned OS = 16,
  parameter int unsigned DW = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic tick_i,
  input  logic line_i,
  input  logic busy_i,
  input  logic char9_i,
  output logic idle_o,
  output logic hit_o
);
  localparam int unsigned TW = $clog2((DW + 2) * OS + 1);

  logic [TW-1:0] cnt;
  logic [TW-1:0] thr;

  assign thr = char9_i ? TW'((DW + 2) * OS) : TW'((DW + 1) * OS);

  always_ff @(posedge clk) begin
    hit_o <= 1'b0;
    if (rst || !en_i || !line_i || busy_i) begin
      cnt    <= '0;
      idle_o <= 1'b0;
    end else if (tick_i && cnt != thr) begin
      cnt <= cnt + 1'b1;
      if (cnt == thr - 1'b1) begin
        idle_o <= 1'b1;
        hit_o  <= 1'b1;
      end
    end
  end

  p_idle_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (!line_i && en_i) |=> !idle_o);

  p_idle_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !idle_o);
endmodule

// File: rtl/rx_wake_ctrl.sv
module rx_wake_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic sel_i,
  input  logic hit_i,
  input  logic done_i,
  input  logic msb_i,
  output logic standby_o,
  output logic deliver_o
);
  logic wake_ev;

  assign wake_ev   = sel_i ? (done_i && msb_i) : hit_i;
  assign deliver_o = done_i && (!standby_o || (sel_i && msb_i));

  always_ff @(posedge clk) begin
    if (rst)                       standby_o <= 1'b0;
    else if (wr_i)                 standby_o <= wdata_i;
    else if (standby_o && wake_ev) standby_o <= 1'b0;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (standby_o && !wr_i && !done_i && !hit_i) |=> standby_o);

  p_write_r7: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (standby_o == $past(wdata_i)));
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake #(
  parameter int unsigned OS     = 16,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line_i,
  input  logic              os_tick_i,
  input  logic              rx_en_i,
  input  logic              wake_sel_i,
  input  logic              standby_wr_i,
  input  logic              standby_wdata_i,
  input  logic              char9_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              idle_o,
  output logic              standby_o
);
  logic [1:0]        sync_q;
  logic              line_s;
  logic              done;
  logic              busy;
  logic              hit;
  logic              deliver;
  logic              msb;
  logic [DATA_W-1:0] chr;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rx_line_i};
  end
  assign line_s = sync_q[1];

  rx_sampler #(.OS(OS), .DW(DATA_W)) u_sampler (
    .clk(clk), .rst(rst), .en_i(rx_en_i), .tick_i(os_tick_i),
    .line_i(line_s), .char9_i(char9_i), .done_o(done), .data_o(chr),
    .busy_o(busy)
  );

  rx_idle_det #(.OS(OS), .DW(DATA_W)) u_idle (
    .clk(clk), .rst(rst), .en_i(rx_en_i), .tick_i(os_tick_i),
    .line_i(line_s), .busy_i(busy), .char9_i(char9_i),
    .idle_o(idle_o), .hit_o(hit)
  );

  assign msb = char9_i ? chr[DATA_W-1] : chr[DATA_W-2];

  rx_wake_ctrl u_wake (
    .clk(clk), .rst(rst), .wr_i(standby_wr_i), .wdata_i(standby_wdata_i),
    .sel_i(wake_sel_i), .hit_i(hit), .done_i(done), .msb_i(msb),
    .standby_o(standby_o), .deliver_o(deliver)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= deliver;
      if (deliver) rx_data_o <= chr;
    end
  end

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!rx_en_i && $past(!rx_en_i)) |-> !rx_valid_o);

  p_idle_silent_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(standby_o) && !$past(wake_sel_i) && !$past(standby_wr_i))
      |-> !rx_valid_o);

  p_idle_wake_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(standby_o) && !$past(standby_wr_i) && !$past(wake_sel_i))
      |-> $past(idle_o));

  p_addr_wake_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_o && $past(standby_o) && !$past(standby_wr_i))
      |-> (!standby_o && ($past(char9_i) ? rx_data_o[DATA_W-1]
                                         : rx_data_o[DATA_W-2])));
endmodule

// File: tb/uart_rx_wake_bench.sv
module uart_rx_wake_bench;
  localparam int BIT = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line = 1'b1;
  logic       tick = 1'b0;
  logic       en = 1'b0;
  logic       wsel = 1'b0;
  logic       swr = 1'b0;
  logic       swd = 1'b0;
  logic       c9 = 1'b0;
  logic [8:0] data;
  logic       valid;
  logic       idle;
  logic       stby;

  int checks = 0;
  int errors = 0;
  int vcnt = 0;
  logic [8:0] last = '0;
  logic [1:0] div = '0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_rx_wake u_uart_rx_wake (
    .clk(clk), .rst(rst), .rx_line_i(line), .os_tick_i(tick),
    .rx_en_i(en), .wake_sel_i(wsel), .standby_wr_i(swr),
    .standby_wdata_i(swd), .char9_i(c9), .rx_data_o(data),
    .rx_valid_o(valid), .idle_o(idle), .standby_o(stby)
  );

  always @(negedge clk) begin
    div  <= div + 2'd1;
    tick <= (div == 2'd3);
    if (valid) begin
      vcnt <= vcnt + 1;
      last <= data;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input bit n9, input bit stop_v);
    line = 1'b0; wait_clk(BIT);
    for (int i = 0; i < (n9 ? 9 : 8); i++) begin
      line = d[i]; wait_clk(BIT);
    end
    line = stop_v; wait_clk(BIT);
    line = 1'b1; wait_clk(20);
  endtask

  task automatic sb_write(input bit v);
    swr = 1'b1; swd = v; wait_clk(1);
    swr = 1'b0; swd = 1'b0; wait_clk(1);
  endtask

  task automatic t_reset();
    wait_clk(3);
    check(valid == 0 && data == 0, "R10 outputs after reset", data, 0);
    check(idle == 0 && stby == 0, "R10 flags after reset", {idle, stby}, 0);
  endtask

  task automatic t_basic8();
    int c0;
    en = 1'b1; wait_clk(BIT * 12);
    c0 = vcnt;
    send(9'h0A5, 0, 1);
    check(vcnt == c0 + 1 && last == 9'h0A5, "R2 char A5", last, 9'h0A5);
    send(9'h03C, 0, 1);
    check(vcnt == c0 + 2 && last == 9'h03C, "R2 char 3C single pulse each", vcnt - c0, 2);
  endtask

  task automatic t_nine();
    int c0;
    c9 = 1'b1; c0 = vcnt;
    send(9'h1C3, 1, 1);
    check(vcnt == c0 + 1 && last == 9'h1C3, "R3 nine-bit char", last, 9'h1C3);
    c9 = 1'b0; wait_clk(BIT * 12);
  endtask

  task automatic t_disabled();
    int c0;
    en = 1'b0; c0 = vcnt;
    send(9'h055, 0, 1);
    wait_clk(BIT * 12);
    check(vcnt == c0, "R1 no data while disabled", vcnt - c0, 0);
    check(idle == 0, "R1 idle held low while disabled", idle, 0);
    en = 1'b1;
    send(9'h066, 0, 1);
    check(vcnt == c0 + 1 && last == 9'h066, "R1 works after enable", last, 9'h066);
  endtask

  task automatic t_glitch();
    int c0;
    c0 = vcnt;
    line = 1'b0; wait_clk(12); line = 1'b1; wait_clk(BIT * 12);
    check(vcnt == c0, "R4 short low pulse rejected", vcnt - c0, 0);
    send(9'h0C9, 0, 1);
    check(vcnt == c0 + 1 && last == 9'h0C9, "R4 char after glitch", last, 9'h0C9);
  endtask

  task automatic t_frame();
    int c0;
    c0 = vcnt;
    send(9'h0F0, 0, 0);
    wait_clk(BIT * 12);
    check(vcnt == c0, "R5 bad stop bit drops char", vcnt - c0, 0);
  endtask

  task automatic t_idle();
    send(9'h011, 0, 1);
    check(idle == 0, "R6 idle low right after char", idle, 0);
    wait_clk(BIT * 8);
    check(idle == 0, "R6 idle low before char time", idle, 0);
    wait_clk(BIT * 4);
    check(idle == 1, "R6 idle high after char time", idle, 1);
    line = 1'b0; wait_clk(6);
    check(idle == 0, "R6 idle drops on low line", idle, 0);
    line = 1'b1; wait_clk(BIT * 12);
  endtask

  task automatic t_idle_wake();
    int c0;
    wsel = 1'b0; wait_clk(BIT * 12);
    sb_write(1);
    check(stby == 1, "R7 standby entered", stby, 1);
    wait_clk(BIT * 12);
    check(stby == 1, "R8 old idle does not wake", stby, 1);
    c0 = vcnt;
    send(9'h0AA, 0, 1);
    check(vcnt == c0 && stby == 1, "R8 char hidden in standby", vcnt - c0, 0);
    wait_clk(BIT * 12);
    check(stby == 0, "R8 idle wakes receiver", stby, 0);
    send(9'h022, 0, 1);
    check(vcnt == c0 + 1 && last == 9'h022, "R8 next char delivered", last, 9'h022);
  endtask

  task automatic t_addr_wake8();
    int c0;
    wsel = 1'b1; wait_clk(BIT * 12);
    sb_write(1); c0 = vcnt;
    send(9'h005, 0, 1);
    check(vcnt == c0 && stby == 1, "R9 msb 0 char dropped", vcnt - c0, 0);
    wait_clk(BIT * 12);
    check(stby == 1, "R9 idle ignored in mark mode", stby, 1);
    send(9'h085, 0, 1);
    check(vcnt == c0 + 1 && last == 9'h085, "R9 mark char delivered", last, 9'h085);
    check(stby == 0, "R9 mark clears standby", stby, 0);
    send(9'h006, 0, 1);
    check(vcnt == c0 + 2 && last == 9'h006, "R9 normal after wake", last, 9'h006);
  endtask

  task automatic t_addr_wake9();
    int c0;
    c9 = 1'b1; wsel = 1'b1; wait_clk(BIT * 12);
    sb_write(1); c0 = vcnt;
    send(9'h0FF, 1, 1);
    check(vcnt == c0 && stby == 1, "R3 bit 7 is not the mark in 9-bit", vcnt - c0, 0);
    send(9'h101, 1, 1);
    check(vcnt == c0 + 1 && last == 9'h101 && stby == 0, "R9 bit 8 mark wakes", last, 9'h101);
    c9 = 1'b0; wait_clk(BIT * 12);
  endtask

  task automatic t_sw_clear();
    int c0;
    wsel = 1'b0;
    sb_write(1);
    check(stby == 1, "R7 write one", stby, 1);
    sb_write(0);
    check(stby == 0, "R7 write zero leaves standby", stby, 0);
    c0 = vcnt;
    send(9'h07E, 0, 1);
    check(vcnt == c0 + 1 && last == 9'h07E, "R7 delivery after clear", last, 9'h07E);
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    t_reset();
    t_basic8();
    t_nine();
    t_disabled();
    t_glitch();
    t_frame();
    t_idle();
    t_idle_wake();
    t_addr_wake8();
    t_addr_wake9();
    t_sw_clear();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule